// File: doc/BRIEF.md
# Daisy-Chain Converter Serial Port

This block is the digital side of one sampling converter whose result leaves on a three-wire serial bus: a conversion strobe, a serial clock, and a data line in each direction. The host raises the conversion strobe while the serial clock is low. That edge starts a conversion, selects chained readback, and captures the parallel word on `sample_i`, which stands in for the analog sample. The strobe then stays high for the whole conversion and the readback that follows.

A fixed number of system clock cycles later the result is loaded into a shift register, and its most significant bit appears on `sdo_o` with no serial clock edge. After that, each falling edge of the serial clock moves the register one place toward `sdo_o` and takes `sdi_i` in at the least significant end. Several ports can be cascaded by wiring each `sdo_o` to the next `sdi_i`. A chain of N ports then delivers all of its words in DATA_W×N falling edges. The strobe and the serial clock are sampled on the system clock, and falling edges are found by comparing each sample with the one before it.

Top module: `chain_adc_port`

## Requirements
- R1: While `rst_n` is low and after its release, the port is idle and `sdo_o` is 0.
- R2: A clock on which `cnv_i` is 1 after being 0 on the previous clock, with `sck_i` at 0, starts a conversion and captures `sample_i`. If `sck_i` is 1 on that clock, no conversion starts and `sdo_o` stays 0.
- R3: The conversion lasts CONV_CYCLES system clocks. On the CONV_CYCLES-th rising edge after the edge that saw the strobe rise, the captured word is loaded, and `sdo_o` then shows its MSB without any serial clock edge.
- R4: Falling edges of `sck_i` during the conversion have no effect, so readback still begins at the MSB of the captured word.
- R5: During readback, each falling edge shifts the word one place toward `sdo_o` and enters `sdi_i` at bit 0, so the bits leave MSB first.
- R6: After DATA_W falling edges, `sdo_o` presents the bits that came in from `sdi_i`, in arrival order, and keeps doing so while `cnv_i` stays high. Chained words therefore follow one another.
- R7: While `cnv_i` is 0, the port returns to idle on the next clock, abandoning any conversion or readback. From then on `sdo_o` is 0.
- R8: A falling edge means `sck_i` was 1 on the previous clock and is 0 on this one. Holding `sck_i` at either level shifts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv_i | input | 1 | Conversion strobe, held high through conversion and readback |
| sck_i | input | 1 | Serial clock, sampled on `clk` |
| sdi_i | input | 1 | Serial data from the upstream port |
| sample_i | input | DATA_W | Parallel word captured when the strobe rises |
| sdo_o | output | 1 | Serial data toward the host or the downstream port |

## Verification
The bench builds the port with DATA_W = 16 and CONV_CYCLES = 12. The short conversion leaves room to abort both during the conversion and during readback, and to toggle the serial clock inside the conversion window. The 16-bit word is long enough to shift a full upstream word in behind the local one and to continue past it, so a two-device chain is exercised. A behavioural queue model predicts `sdo_o` for every clock and is compared at each falling edge of `clk`.

// File: rtl/chain_adc_port.sv
module chain_adc_port #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo_o
);

  localparam int CW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(CONV_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_READ} state_t;

  state_t            state;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] cap_q;
  logic [DATA_W-1:0] shreg;
  logic              cnv_q, sck_q;

  wire cnv_rise = cnv_i && !cnv_q;
  wire sck_fall = sck_q && !sck_i;
  wire conv_end = (state == ST_CONV) && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnv_q <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      cnv_q <= cnv_i;
      sck_q <= sck_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      cap_q <= '0;
      shreg <= '0;
    end else if (!cnv_i) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (cnv_rise && !sck_i) begin
          state <= ST_CONV;
          cnt   <= '0;
          cap_q <= sample_i;
        end
        ST_CONV: begin
          if (conv_end) begin
            state <= ST_READ;
            shreg <= cap_q;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_READ: if (sck_fall) shreg <= {shreg[DATA_W-2:0], sdi_i};
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sdo_o = (state == ST_READ) ? shreg[DATA_W-1] : 1'b0;

  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnv_q && !cnv_i) |-> !sdo_o);

  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cnv_i |=> state == ST_IDLE);

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && cnv_rise && !sck_i) |=> (state == ST_CONV && cnt == '0));

  assert_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && sck_i) |=> state == ST_IDLE);

  assert_conv_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV && cnt != CNT_LAST && cnv_i) |=> (state == ST_CONV && !sdo_o));

  assert_load_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_end && cnv_i) |=> (state == ST_READ && sdo_o == $past(cap_q[DATA_W-1])));

  assert_hold_no_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && cnv_i && !sck_fall) |=> $stable(shreg));

  assert_shift_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && cnv_i && sck_fall) |=> shreg[0] == $past(sdi_i));

endmodule

// File: tb/chain_adc_port_tb.sv
module chain_adc_port_tb;
  localparam int W  = 16;
  localparam int CC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [W-1:0] sample = '0;
  logic sdo;

  always #5 clk = ~clk;

  chain_adc_port #(.DATA_W(W), .CONV_CYCLES(CC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sck_i(sck), .sdi_i(sdi),
    .sample_i(sample), .sdo_o(sdo));

  int vectors = 0, miscompares = 0, cycles = 0;
  string cur_req = "R1";

  int   ms = 0, mcnt = 0;
  logic [W-1:0] mcap = '0;
  bit   mq[$];
  logic m_cnv_prev = 0, m_sck_prev = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mcnt = 0; mq = {}; m_cnv_prev = 0; m_sck_prev = 0;
    end else begin
      if (!cnv) ms = 0;
      else case (ms)
        0: if (!m_cnv_prev && !sck) begin ms = 1; mcnt = 0; mcap = sample; end
        1: if (mcnt == CC - 1) begin
             ms = 2; mq = {};
             for (int i = W - 1; i >= 0; i--) mq.push_back(mcap[i]);
           end else mcnt++;
        default: if (m_sck_prev && !sck) begin void'(mq.pop_front()); mq.push_back(sdi); end
      endcase
      m_cnv_prev = cnv; m_sck_prev = sck;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(negedge clk) begin
    logic exp;
    exp = (ms == 2) ? mq[0] : 1'b0;
    vectors++;
    if (sdo !== exp) begin
      miscompares++;
      $display("FAIL %s t=%0t sdo=%b expected=%b", cur_req, $time, sdo, exp);
    end
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic start(logic [W-1:0] val, logic sck_lvl);
    @(negedge clk); #1;
    sample = val; sck = sck_lvl; cnv = 1'b1;
  endtask

  task automatic shift(int n, logic [W-1:0] word);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1; sck = 1'b1; sdi = word[W - 1 - (i % W)];
      @(negedge clk); #1; sck = 1'b0;
    end
  endtask

  task automatic stop();
    @(negedge clk); #1; cnv = 1'b0; sck = 1'b0; sdi = 1'b0;
    tick(3);
  endtask

  initial begin
    cur_req = "R1"; tick(4); rst_n = 1'b1; tick(3);

    cur_req = "R3"; start(16'hA5C3, 1'b0); tick(CC + 2);
    cur_req = "R5"; shift(W, 16'h1234);
    cur_req = "R6"; shift(8, 16'hF00F); tick(3); stop();

    cur_req = "R4"; start(16'h8001, 1'b0);
    for (int i = 0; i < CC / 2 - 1; i++) begin @(negedge clk); #1; sck = ~sck; end
    @(negedge clk); #1; sck = 1'b0; tick(CC);
    cur_req = "R5"; shift(W + 4, 16'hBEEF); stop();

    cur_req = "R2"; start(16'hFFFF, 1'b1); tick(CC + 3);
    @(negedge clk); #1; sck = 1'b0; tick(2); shift(4, 16'hFFFF); stop();

    cur_req = "R7"; start(16'hFFFF, 1'b0); tick(CC / 2); stop();
    start(16'hC0DE, 1'b0); tick(CC + 1); shift(5, 16'h0000); stop();
    @(negedge clk); #1; sdi = 1'b1; tick(4); sdi = 1'b0;

    cur_req = "R8"; start(16'h6A96, 1'b0); tick(CC + 1);
    @(negedge clk); #1; sck = 1'b1; tick(6);
    @(negedge clk); #1; sck = 1'b0; tick(6);
    shift(W, 16'h55AA); stop();

    cur_req = "R1"; @(negedge clk); #1; rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3);
    summary();
  end
endmodule